// File: doc/BRIEF.md
# DMA Controller Register Port

This block is the byte-wide programming side of a four-channel DMA controller. A host reaches it through a small I/O window: one chip select, separate read and write strobes, a 5-bit port number and a byte of data. Behind the window sit four kinds of per-channel state: a 16-bit base address, a 16-bit base word count, an 8-bit mode byte and an 8-bit page byte. Global state is a four-bit channel mask and a status byte. Each 16-bit quantity moves over the byte bus in two steps. A single pointer bit, shared by every channel, decides whether an access reaches the low byte or the high byte.

The controller also holds a current address and a current count for each channel. Programming the high byte of a base register copies the complete base value into its current register. After that, the transfer engine moves the current copy forward through an update input. The host always reads back the current copies. Several ports only carry commands: they reset the pointer, mask or unmask channels, or do both at once. The value written to such a port is ignored except where a data field is defined.

Port map (5-bit port number): 0x00–0x07 are channel address/count ports; 0x08 status; 0x0A single mask; 0x0B mode; 0x0C pointer reset; 0x0D master clear; 0x0E unmask all; 0x0F load mask; 0x10–0x13 page bytes of channels 0–3. All other numbers are unused.

Top module: `dmac_regport`

## Requirements
- R1: Channel n's address register sits at port 2n and its count register at port 2n+1. A write goes to the low byte while the pointer is clear and to the high byte while it is set. The result appears on the base_addr/base_count outputs (channel n in bits 16n+15:16n).
- R2: One pointer bit serves all four channels. It starts clear after reset, and every read or write of any port 0x00–0x07 inverts it.
- R3: A low-byte write leaves the current register unchanged. A high-byte write also loads the complete new 16-bit base value into the matching current address or current count.
- R4: Reads of ports 0x00–0x07 return the low or high byte of the current register, never the base. An engine update (upd_valid with channel upd_ch) replaces the current address and count of that channel and leaves both base registers alone.
- R5: A write to the mode port (0x0B) stores the whole data byte as the mode of the channel named by data bits 1:0. That channel's mode appears on chan_mode bits 8n+7:8n. The mode port reads as zero.
- R6: A write to the single-mask port (0x0A) sets mask bit (data bits 1:0) when data bit 2 is 1 and clears it when data bit 2 is 0. The other mask bits are unchanged.
- R7: A write to the load-mask port (0x0F) copies data bits 3:0 into the mask (bit n masks channel n).
- R8: Any write to port 0x0C clears the pointer, whatever the data.
- R9: A write to port 0x0D clears the pointer and masks all four channels. A write to port 0x0E unmasks all four channels.
- R10: After reset the mask is 4'hF, the status byte is zero, every mode is zero and every base/current register is zero.
- R11: Status bit n (n = 0..3) is set by a one-cycle pulse on tc_in[n] and stays set. Bits 7:4 show dreq_in[3:0] live. Reading port 0x08 returns the byte and then clears bits 3:0, except that a tc_in pulse in the same cycle leaves its bit set.
- R12: Port 0x10+n reads and writes channel n's page byte. The page byte forms bits 23:16 of that channel's cur_addr_full word, above the 16-bit current address.
- R13: Unused ports (0x09, 0x14–0x1F) read as zero, and writes to them change no mask, mode, base register or pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select for the I/O window |
| wr_en | input | 1 | Write strobe (takes precedence over rd_en) |
| rd_en | input | 1 | Read strobe |
| addr | input | 5 | Port number |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data, valid in the read cycle, zero otherwise |
| upd_valid | input | 1 | Engine update of current registers |
| upd_ch | input | 2 | Channel that the engine updates |
| upd_addr | input | 16 | New current address |
| upd_cnt | input | 16 | New current count |
| tc_in | input | 4 | Terminal-count pulses, one per channel |
| dreq_in | input | 4 | Live request lines, one per channel |
| chan_mask | output | 4 | Mask bits, 1 = channel masked |
| chan_mode | output | 32 | Mode bytes, channel n in bits 8n+7:8n |
| cur_addr_full | output | 96 | {page, current address} for each channel, 24 bits each |
| cur_count | output | 64 | Current counts, 16 bits each |
| base_addr | output | 64 | Base addresses, 16 bits each |
| base_count | output | 64 | Base counts, 16 bits each |

## Verification
The bench interleaves accesses to different channels and mixes reads with writes to show that the pointer is a single shared bit. A design with a pointer per channel, or one that toggles only on writes, would return the wrong byte on the read that follows a write to another channel. It checks that a low-byte write leaves the current register alone and that engine updates never disturb the base registers. A design that copied on every byte, or read back the base, would show stale or half-written values. The bench also checks a status read that coincides with a terminal-count pulse, where clearing first would drop the event. It checks that master clear resets the pointer as well as the mask, and that writes to unused ports leave every register and the pointer untouched.

// File: rtl/dmac_regport_pkg.sv
// Shared constants of the DMA register port: bus widths and the port map.
// Assumes four channels, so that channel and control ports fill 0x00-0x0F.
package dmac_regport_pkg;
    localparam int NCH    = 4;
    localparam int DW     = 8;
    localparam int AW     = 5;
    localparam int PAGE_W = 8;

    localparam logic [AW-1:0] PORT_STATUS = 5'h08;
    localparam logic [AW-1:0] PORT_SMASK  = 5'h0A;
    localparam logic [AW-1:0] PORT_MODE   = 5'h0B;
    localparam logic [AW-1:0] PORT_FFCLR  = 5'h0C;
    localparam logic [AW-1:0] PORT_MCLR   = 5'h0D;
    localparam logic [AW-1:0] PORT_UNMASK = 5'h0E;
    localparam logic [AW-1:0] PORT_AMASK  = 5'h0F;
    localparam logic [AW-1:0] PORT_PAGE0  = 5'h10;
endpackage

// File: rtl/dmac_byte_ptr.sv
// Shared low/high byte pointer. Inverts on each channel-port access and
// returns to low on a clear. Assumes toggle and clear never coincide.
module dmac_byte_ptr (
    input  logic clk,
    input  logic rst_n,
    input  logic toggle,
    input  logic clear,
    output logic ptr
);
    // Pointer state: clear has priority, otherwise flip on access
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr <= 1'b0;
        else if (clear)  ptr <= 1'b0;
        else if (toggle) ptr <= ~ptr;
    end
endmodule

// File: rtl/dmac_chan_regs.sv
// One channel's register set: base and current address and count, plus
// the page byte. The host write path has priority over an engine update
// in the same cycle. Assumes the byte strobes are already decoded.
module dmac_chan_regs #(
    parameter int DW     = 8,
    parameter int PAGE_W = 8,
    localparam int RW    = 2 * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr_lo,
    input  logic              wr_addr_hi,
    input  logic              wr_cnt_lo,
    input  logic              wr_cnt_hi,
    input  logic              wr_page,
    input  logic [DW-1:0]     wdata,
    input  logic              upd_en,
    input  logic [RW-1:0]     upd_addr,
    input  logic [RW-1:0]     upd_cnt,
    output logic [RW-1:0]     base_addr,
    output logic [RW-1:0]     base_cnt,
    output logic [RW-1:0]     cur_addr,
    output logic [RW-1:0]     cur_cnt,
    output logic [PAGE_W-1:0] page
);
    // Base address: byte-wise host loads
    always_ff @(posedge clk) begin
        if (!rst_n)          base_addr <= '0;
        else if (wr_addr_lo) base_addr[DW-1:0]  <= wdata;
        else if (wr_addr_hi) base_addr[RW-1:DW] <= wdata;
    end

    // Base count: byte-wise host loads
    always_ff @(posedge clk) begin
        if (!rst_n)         base_cnt <= '0;
        else if (wr_cnt_lo) base_cnt[DW-1:0]  <= wdata;
        else if (wr_cnt_hi) base_cnt[RW-1:DW] <= wdata;
    end

    // Current address: copy of base on high-byte write, else engine update
    always_ff @(posedge clk) begin
        if (!rst_n)          cur_addr <= '0;
        else if (wr_addr_hi) cur_addr <= {wdata, base_addr[DW-1:0]};
        else if (upd_en)     cur_addr <= upd_addr;
    end

    // Current count: copy of base on high-byte write, else engine update
    always_ff @(posedge clk) begin
        if (!rst_n)         cur_cnt <= '0;
        else if (wr_cnt_hi) cur_cnt <= {wdata, base_cnt[DW-1:0]};
        else if (upd_en)    cur_cnt <= upd_cnt;
    end

    // Page byte: upper address bits of this channel
    always_ff @(posedge clk) begin
        if (!rst_n)       page <= '0;
        else if (wr_page) page <= wdata[PAGE_W-1:0];
    end
endmodule

// File: rtl/dmac_ctrl_regs.sv
// Global control state: mask bits, mode bytes and status byte. Command
// strobes arrive decoded; only one is active in a cycle. Assumes NCH is a
// power of two so that the low data bits always name a valid channel.
module dmac_ctrl_regs #(
    parameter int NCH  = 4,
    parameter int DW   = 8,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DW-1:0]         wdata,
    input  logic                  wr_smask,
    input  logic                  wr_amask,
    input  logic                  wr_mclr,
    input  logic                  wr_unmask,
    input  logic                  wr_mode,
    input  logic                  rd_status,
    input  logic [NCH-1:0]        tc_in,
    input  logic [NCH-1:0]        dreq_in,
    output logic [NCH-1:0]        mask,
    output logic [NCH-1:0][DW-1:0] mode,
    output logic [DW-1:0]         status
);
    logic [NCH-1:0] tc_q;
    logic [CH_W-1:0] sel;
    assign sel = wdata[CH_W-1:0];

    // Mask register: full masks, full unmask, load, or single-bit edit
    always_ff @(posedge clk) begin
        if (!rst_n)         mask <= '1;
        else if (wr_mclr)   mask <= '1;
        else if (wr_unmask) mask <= '0;
        else if (wr_amask)  mask <= wdata[NCH-1:0];
        else if (wr_smask)  mask[sel] <= wdata[CH_W];
    end

    // Mode bytes: whole byte stored for the channel named in the low bits
    always_ff @(posedge clk) begin
        if (!rst_n)       mode <= '0;
        else if (wr_mode) mode[sel] <= wdata;
    end

    // Terminal-count flags: sticky, cleared by a status read, new pulse wins
    always_ff @(posedge clk) begin
        if (!rst_n)         tc_q <= '0;
        else if (rd_status) tc_q <= tc_in;
        else                tc_q <= tc_q | tc_in;
    end

    // Status byte: live requests above, sticky terminal counts below
    always_comb begin
        status = '0;
        status[NCH-1:0]       = tc_q;
        status[2*NCH-1:NCH]   = dreq_in;
    end
endmodule

// File: rtl/dmac_regport.sv
// DMA controller register port: decodes the byte-wide host window into the
// channel register sets, the shared byte pointer and the control state,
// and muxes read data. Assumes wr_en wins when both strobes are high and
// that read data is taken in the strobe cycle.
module dmac_regport
    import dmac_regport_pkg::*;
#(
    parameter int NCH_P = NCH,
    parameter int DW_P  = DW,
    parameter int AW_P  = AW,
    localparam int RW   = 2 * DW_P,
    localparam int FW   = PAGE_W + RW,
    localparam int CH_W = $clog2(NCH_P)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [AW_P-1:0]      addr,
    input  logic [DW_P-1:0]      wdata,
    output logic [DW_P-1:0]      rdata,
    input  logic                 upd_valid,
    input  logic [CH_W-1:0]      upd_ch,
    input  logic [RW-1:0]        upd_addr,
    input  logic [RW-1:0]        upd_cnt,
    input  logic [NCH_P-1:0]     tc_in,
    input  logic [NCH_P-1:0]     dreq_in,
    output logic [NCH_P-1:0]     chan_mask,
    output logic [NCH_P*DW_P-1:0] chan_mode,
    output logic [NCH_P*FW-1:0]  cur_addr_full,
    output logic [NCH_P*RW-1:0]  cur_count,
    output logic [NCH_P*RW-1:0]  base_addr,
    output logic [NCH_P*RW-1:0]  base_count
);
    localparam logic [AW_P-1:0] CHAN_END = AW_P'(2 * NCH_P);

    logic wr_stb, rd_stb, chan_hit, page_hit, ptr_q;
    logic [DW_P-1:0] status_b;
    logic [NCH_P-1:0][DW_P-1:0] mode_v;
    logic [NCH_P-1:0][RW-1:0] cur_a, cur_c, base_a, base_c;
    logic [NCH_P-1:0][PAGE_W-1:0] page_v;

    // Strobe qualification and region decode
    assign wr_stb   = cs & wr_en;
    assign rd_stb   = cs & rd_en & ~wr_en;
    assign chan_hit = (addr < CHAN_END);
    assign page_hit = (addr[AW_P-1:CH_W] == PORT_PAGE0[AW_P-1:CH_W]);

    dmac_byte_ptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .toggle ((wr_stb | rd_stb) & chan_hit),
        .clear  (wr_stb & ((addr == PORT_FFCLR) | (addr == PORT_MCLR))),
        .ptr    (ptr_q)
    );

    for (genvar n = 0; n < NCH_P; n++) begin : g_chan
        logic hit_n, page_n;
        assign hit_n  = wr_stb & chan_hit & (addr[CH_W:1] == CH_W'(n));
        assign page_n = wr_stb & page_hit & (addr[CH_W-1:0] == CH_W'(n));

        dmac_chan_regs #(.DW(DW_P), .PAGE_W(PAGE_W)) u_regs (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_addr_lo (hit_n & ~addr[0] & ~ptr_q),
            .wr_addr_hi (hit_n & ~addr[0] &  ptr_q),
            .wr_cnt_lo  (hit_n &  addr[0] & ~ptr_q),
            .wr_cnt_hi  (hit_n &  addr[0] &  ptr_q),
            .wr_page    (page_n),
            .wdata      (wdata),
            .upd_en     (upd_valid & (upd_ch == CH_W'(n))),
            .upd_addr   (upd_addr),
            .upd_cnt    (upd_cnt),
            .base_addr  (base_a[n]),
            .base_cnt   (base_c[n]),
            .cur_addr   (cur_a[n]),
            .cur_cnt    (cur_c[n]),
            .page       (page_v[n])
        );

        assign cur_addr_full[n*FW +: FW] = {page_v[n], cur_a[n]};
    end

    dmac_ctrl_regs #(.NCH(NCH_P), .DW(DW_P)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wdata     (wdata),
        .wr_smask  (wr_stb & (addr == PORT_SMASK)),
        .wr_amask  (wr_stb & (addr == PORT_AMASK)),
        .wr_mclr   (wr_stb & (addr == PORT_MCLR)),
        .wr_unmask (wr_stb & (addr == PORT_UNMASK)),
        .wr_mode   (wr_stb & (addr == PORT_MODE)),
        .rd_status (rd_stb & (addr == PORT_STATUS)),
        .tc_in     (tc_in),
        .dreq_in   (dreq_in),
        .mask      (chan_mask),
        .mode      (mode_v),
        .status    (status_b)
    );

    assign chan_mode  = mode_v;
    assign cur_count  = cur_c;
    assign base_addr  = base_a;
    assign base_count = base_c;

    // Read mux: current register byte, status, page, else zero
    always_comb begin
        logic [RW-1:0] word;
        word  = '0;
        rdata = '0;
        if (rd_stb) begin
            if (chan_hit) begin
                word  = addr[0] ? cur_c[addr[CH_W:1]] : cur_a[addr[CH_W:1]];
                rdata = ptr_q ? word[RW-1:DW_P] : word[DW_P-1:0];
            end else if (addr == PORT_STATUS) begin
                rdata = status_b;
            end else if (page_hit) begin
                rdata = page_v[addr[CH_W-1:0]];
            end
        end
    end
endmodule

// File: rtl/dmac_regport_chk.sv
// Property checker for the DMA register port, bound into every instance.
module dmac_regport_chk
    import dmac_regport_pkg::*;
#(
    parameter int NCH_P = NCH,
    parameter int DW_P  = DW,
    parameter int AW_P  = AW,
    localparam int CH_W = $clog2(NCH_P)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cs,
    input logic                  wr_en,
    input logic                  rd_en,
    input logic [AW_P-1:0]       addr,
    input logic [DW_P-1:0]       wdata,
    input logic [NCH_P-1:0]      tc_in,
    input logic [NCH_P-1:0]      chan_mask,
    input logic [NCH_P*DW_P-1:0] chan_mode,
    input logic [DW_P-1:0]       status_b,
    input logic                  ptr_q
);
    logic wr_c, rd_c, chan_c, undef_c;
    logic [NCH_P-1:0][DW_P-1:0] mode_v;
    assign mode_v  = chan_mode;
    assign wr_c    = cs & wr_en;
    assign rd_c    = cs & rd_en & ~wr_en;
    assign chan_c  = (addr < AW_P'(2 * NCH_P));
    assign undef_c = (addr == 5'h09) | (addr > 5'h13);

    AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_c | rd_c) & chan_c |=> ptr_q != $past(ptr_q)); // R2
    AST_MODE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_c & (addr == PORT_MODE) |=> mode_v[$past(wdata[CH_W-1:0])] == $past(wdata)); // R5
    AST_LOAD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_c & (addr == PORT_AMASK) |=> chan_mask == $past(wdata[NCH_P-1:0])); // R7
    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_c & (addr == PORT_FFCLR) |=> !ptr_q); // R8
    AST_MASTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_c & (addr == PORT_MCLR) |=> chan_mask == '1 && !ptr_q); // R9
    AST_UNMASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_c & (addr == PORT_UNMASK) |=> chan_mask == '0); // R9
    AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_c & (addr == PORT_STATUS) & (tc_in == '0) |=> status_b[NCH_P-1:0] == '0); // R11
    AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_c & undef_c |=> $stable(chan_mask) && $stable(chan_mode) && $stable(ptr_q)); // R13
endmodule

bind dmac_regport dmac_regport_chk #(.NCH_P(NCH_P), .DW_P(DW_P), .AW_P(AW_P)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (cs),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .tc_in     (tc_in),
    .chan_mask (chan_mask),
    .chan_mode (chan_mode),
    .status_b  (status_b),
    .ptr_q     (ptr_q)
);

// File: tb/test_dmac_regport.sv
// Directed bench for the DMA register port; one task per scenario.
module test_dmac_regport;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        upd_valid = 1'b0;
    logic [1:0]  upd_ch = '0;
    logic [15:0] upd_addr = '0, upd_cnt = '0;
    logic [3:0]  tc_in = '0, dreq_in = '0;
    logic [3:0]  chan_mask;
    logic [31:0] chan_mode;
    logic [95:0] cur_addr_full;
    logic [63:0] cur_count, base_addr, base_count;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dmac_regport i_dmac_regport (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .upd_valid(upd_valid),
        .upd_ch(upd_ch), .upd_addr(upd_addr), .upd_cnt(upd_cnt),
        .tc_in(tc_in), .dreq_in(dreq_in), .chan_mask(chan_mask),
        .chan_mode(chan_mode), .cur_addr_full(cur_addr_full),
        .cur_count(cur_count), .base_addr(base_addr), .base_count(base_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        cs = 1'b0; rd_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R10 mask", 32'(chan_mask), 32'hF);
        chk("R10 mode", chan_mode, 32'h0);
        chk("R10 base", base_addr[31:0], 32'h0);
        rd(5'h08, d);
        chk("R10 status", 32'(d), 32'h0);
    endtask

    task automatic t_addr_count;
        logic [7:0] d;
        wr(5'h0C, 8'h00);
        wr(5'h02, 8'h34);
        chk("R1 base low", 32'(base_addr[31:16]), 32'h0034);
        chk("R3 no copy on low", 32'(cur_addr_full[47:24]), 32'h0);
        wr(5'h02, 8'h12);
        chk("R1 base high", 32'(base_addr[31:16]), 32'h1234);
        chk("R3 copy on high", 32'(cur_addr_full[39:24]), 32'h1234);
        wr(5'h05, 8'hEF);
        wr(5'h05, 8'hBE);
        chk("R1 count", 32'(base_count[47:32]), 32'hBEEF);
        chk("R3 count copy", 32'(cur_count[47:32]), 32'hBEEF);
        rd(5'h02, d);
        chk("R4 read low", 32'(d), 32'h34);
        rd(5'h02, d);
        chk("R4 read high", 32'(d), 32'h12);
    endtask

    task automatic t_shared_ptr;
        logic [7:0] d;
        wr(5'h0C, 8'h00);
        wr(5'h00, 8'h11);
        rd(5'h05, d);
        chk("R2 shared ptr high", 32'(d), 32'hBE);
        rd(5'h05, d);
        chk("R2 read toggles", 32'(d), 32'hEF);
        wr(5'h0C, 8'hA7);
        wr(5'h00, 8'h33);
        chk("R8 ptr cleared", 32'(base_addr[15:0]), 32'h0033);
        wr(5'h00, 8'h44);
        chk("R1 ch0 high", 32'(base_addr[15:0]), 32'h4433);
    endtask

    task automatic t_current;
        logic [7:0] d;
        @(negedge clk);
        upd_valid = 1'b1; upd_ch = 2'd1; upd_addr = 16'h5555; upd_cnt = 16'h0009;
        @(negedge clk);
        upd_valid = 1'b0;
        wr(5'h0C, 8'h00);
        rd(5'h03, d);
        chk("R4 current count low", 32'(d), 32'h09);
        rd(5'h03, d);
        chk("R4 current count high", 32'(d), 32'h00);
        rd(5'h02, d);
        chk("R4 current addr", 32'(d), 32'h55);
        chk("R4 base kept", 32'(base_addr[31:16]), 32'h1234);
        chk("R4 base count kept", 32'(base_count[31:16]), 32'h0);
        wr(5'h0C, 8'h00);
    endtask

    task automatic t_mode;
        logic [7:0] d;
        wr(5'h0B, 8'h46);
        chk("R5 mode ch2", 32'(chan_mode[23:16]), 32'h46);
        wr(5'h0B, 8'h87);
        chk("R5 mode ch3", 32'(chan_mode[31:24]), 32'h87);
        chk("R5 ch2 kept", 32'(chan_mode[23:16]), 32'h46);
        rd(5'h0B, d);
        chk("R5 mode reads zero", 32'(d), 32'h0);
    endtask

    task automatic t_mask;
        wr(5'h0E, 8'h00);
        chk("R9 unmask all", 32'(chan_mask), 32'h0);
        wr(5'h0A, 8'h05);
        chk("R6 set ch1", 32'(chan_mask), 32'h2);
        wr(5'h0A, 8'h06);
        chk("R6 set ch2", 32'(chan_mask), 32'h6);
        wr(5'h0A, 8'h01);
        chk("R6 clear ch1", 32'(chan_mask), 32'h4);
        wr(5'h0F, 8'hF9);
        chk("R7 load mask", 32'(chan_mask), 32'h9);
        wr(5'h00, 8'h77);
        wr(5'h0D, 8'h00);
        chk("R9 master clear mask", 32'(chan_mask), 32'hF);
        wr(5'h00, 8'h99);
        chk("R9 master clear ptr", 32'(base_addr[15:0]), 32'h4499);
        wr(5'h0C, 8'h00);
    endtask

    task automatic t_status;
        logic [7:0] d;
        dreq_in = 4'b1000;
        @(negedge clk); tc_in = 4'b0101;
        @(negedge clk); tc_in = 4'b0000;
        rd(5'h08, d);
        chk("R11 status sticky", 32'(d), 32'h85);
        rd(5'h08, d);
        chk("R11 read clears", 32'(d), 32'h80);
        @(negedge clk);
        cs = 1'b1; rd_en = 1'b1; addr = 5'h08; tc_in = 4'b0010;
        #1 d = rdata;
        @(negedge clk);
        cs = 1'b0; rd_en = 1'b0; tc_in = 4'b0000;
        chk("R11 read before pulse", 32'(d), 32'h80);
        rd(5'h08, d);
        chk("R11 pulse wins clear", 32'(d), 32'h82);
        dreq_in = 4'b0000;
    endtask

    task automatic t_page;
        logic [7:0] d;
        wr(5'h11, 8'hA5);
        chk("R12 page forms bits 23:16", 32'(cur_addr_full[47:24]), 32'hA55555);
        rd(5'h11, d);
        chk("R12 page read", 32'(d), 32'hA5);
    endtask

    task automatic t_undef;
        logic [7:0] d;
        logic [3:0]  m0;
        logic [31:0] md0;
        logic [63:0] b0;
        m0 = chan_mask; md0 = chan_mode; b0 = base_addr;
        wr(5'h09, 8'hFF);
        wr(5'h14, 8'hFF);
        wr(5'h1F, 8'h00);
        chk("R13 mask kept", 32'(chan_mask), 32'(m0));
        chk("R13 mode kept", chan_mode, md0);
        chk("R13 base kept", base_addr[31:0], b0[31:0]);
        wr(5'h00, 8'h5A);
        chk("R13 ptr kept", 32'(base_addr[15:0]), 32'h445A);
        wr(5'h0C, 8'h00);
        rd(5'h09, d);
        chk("R13 read 09", 32'(d), 32'h0);
        rd(5'h1F, d);
        chk("R13 read 1F", 32'(d), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_addr_count();
        t_shared_ptr();
        t_current();
        t_mode();
        t_mask();
        t_status();
        t_page();
        t_undef();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule